// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns parallel words into asynchronous serial frames on a single output line that idles high. A one-word staging register accepts writes from the host side. An internal frame shifter drains that register and sends each word as a frame. The frame holds a low start bit, then the data bits least significant first, then an optional even-parity bit, then one or two high stop bits. An external baud tick sets the pace: the line changes only on the clock edge where the tick is high, so each bit lasts exactly one tick period.

Two status outputs describe the two storage levels. One shows that the staging register can take a new word. The other shows that the shifter is idle and the line has gone quiet. Because there are two levels, the host can write the next word while the current frame is still on the line. When a word is waiting, the next frame follows the last stop bit directly, with no idle gap. The data width, parity and stop count are chosen at run time. They are sampled when a word moves into the shifter.

Top module: `dbuf_uart_tx`

## Requirements
- R1: After reset `tx_line` is 1, `hold_empty` is 1 and `shift_empty` is 1.
- R2: A frame is a start bit of 0 followed by the data bits, least significant bit first. The line changes only on a clock edge where `baud_tick` is 1, so each bit holds for one tick period.
- R3: `cfg_width` selects the data field length: 2'd0 gives 7 bits, 2'd2 gives 9 bits, and 2'd1 or 2'd3 gives 8 bits. Data bits above the selected length are ignored.
- R4: When `cfg_parity` is 1, a parity bit follows the data. It equals the XOR of the sent data bits, which makes the count of ones over data plus parity even.
- R5: `cfg_two_stop` set to 1 ends the frame with two stop bits of 1. Set to 0 it ends the frame with one.
- R6: While the shifter is idle, a word in the staging register moves into the shifter on the next clock edge. At that point `hold_empty` returns to 1 and `shift_empty` falls to 0. The line stays 1 until the next tick, which drives the start bit.
- R7: `hold_empty` is 0 from the clock edge that accepts a write until the word moves into the shifter.
- R8: `shift_empty` stays 0 through the last stop bit. It rises on the tick that ends that bit, and the line is then 1.
- R9: A write while `hold_empty` is 0 is ignored. The pending word is sent unchanged and no extra frame appears.
- R10: If a word is pending when the last stop bit ends, its start bit is driven on that same tick, with no idle bit between the frames.
- R11: The width, parity and stop settings are taken when a word enters the shifter. Changing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| wr_en | input | 1 | Write strobe for the staging register |
| wr_data | input | DATA_W | Word to transmit |
| cfg_width | input | 2 | Data length code (R3) |
| cfg_parity | input | 1 | Append even-parity bit |
| cfg_two_stop | input | 1 | Two stop bits instead of one |
| tx_line | output | 1 | Serial output, idle high |
| hold_empty | output | 1 | Staging register can accept a write |
| shift_empty | output | 1 | Shifter idle and last frame fully sent |

## Verification
The bench uses the default DATA_W of 9, so all three width codes can be reached, including the 9-bit field with parity and two stop bits. That is the longest frame, 13 bits. A tick every four clocks keeps a full frame short enough to run many formats. The bench can also stop the tick, so it can stage words and switch the configuration at known points. This exposes the exact cycle where a word moves into the shifter, the direct start of a second frame, and the settings being sampled only when a word enters the shifter.

// File: rtl/utx_pkg.sv
package utx_pkg;

    typedef enum logic [1:0] {
        SH_IDLE  = 2'd0,
        SH_ARMED = 2'd1,
        SH_SEND  = 2'd2
    } sh_state_e;

    localparam logic [1:0] WCODE_7 = 2'd0;
    localparam logic [1:0] WCODE_9 = 2'd2;

endpackage

// File: rtl/utx_hold_reg.sv
module utx_hold_reg #(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pop,
    output logic              full_o,
    output logic [DATA_W-1:0] data_o
);

    typedef struct packed {
        logic              full;
        logic [DATA_W-1:0] data;
    } hold_t;

    hold_t q, d;

    always_comb begin
        d = q;
        if (pop) begin
            d.full = 1'b0;
        end
        if (wr_en && !q.full) begin
            d.full = 1'b1;
            d.data = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign full_o = q.full;
    assign data_o = q.data;

    // R9: a write that arrives while the word is pending leaves it untouched
    a_r9_keep_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (q.full && wr_en && !pop) |=> $stable(q.data));

endmodule

// File: rtl/utx_framer.sv
module utx_framer #(
    parameter int DATA_W  = 9,
    parameter int FRAME_W = DATA_W + 4,
    parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic [DATA_W-1:0]  data_i,
    input  logic [1:0]         width_i,
    input  logic               parity_en_i,
    input  logic               two_stop_i,
    output logic [FRAME_W-1:0] frame_o,
    output logic [CNT_W-1:0]   len_o
);
    import utx_pkg::*;

    logic [CNT_W-1:0]  nbits;
    logic [DATA_W-1:0] masked;
    logic              parity;

    always_comb begin
        case (width_i)
            WCODE_7: nbits = CNT_W'(7);
            WCODE_9: nbits = CNT_W'(9);
            default: nbits = CNT_W'(8);
        endcase
    end

    for (genvar g = 0; g < DATA_W; g++) begin : g_mask
        assign masked[g] = data_i[g] & (nbits >= CNT_W'(g + 1));
    end

    assign parity = ^masked;

    always_comb begin
        int nb;
        nb = int'(nbits);
        frame_o    = '1;
        frame_o[0] = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < nb) begin
                frame_o[i + 1] = data_i[i];
            end
        end
        if (parity_en_i) begin
            frame_o[nb + 1] = parity;
        end
        len_o = nbits + CNT_W'(1) + CNT_W'(parity_en_i) + (two_stop_i ? CNT_W'(2) : CNT_W'(1));
    end

endmodule

// File: rtl/utx_shifter.sv
module utx_shifter #(
    parameter int FRAME_W = 13,
    parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               hold_full,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic [CNT_W-1:0]   len_i,
    output logic               pop_o,
    output logic               line_o,
    output logic               empty_o
);
    import utx_pkg::*;

    typedef struct packed {
        sh_state_e          state;
        logic [FRAME_W-1:0] sh;
        logic [CNT_W-1:0]   cnt;
        logic               line;
    } shift_t;

    shift_t q, d;

    always_comb begin
        d     = q;
        pop_o = 1'b0;
        case (q.state)
            SH_IDLE: begin
                if (hold_full) begin
                    pop_o   = 1'b1;
                    d.state = SH_ARMED;
                    d.sh    = frame_i;
                    d.cnt   = len_i;
                end
            end
            SH_ARMED: begin
                if (tick) begin
                    d.line  = q.sh[0];
                    d.sh    = {1'b1, q.sh[FRAME_W-1:1]};
                    d.cnt   = q.cnt - CNT_W'(1);
                    d.state = SH_SEND;
                end
            end
            SH_SEND: begin
                if (tick) begin
                    if (q.cnt != '0) begin
                        d.line = q.sh[0];
                        d.sh   = {1'b1, q.sh[FRAME_W-1:1]};
                        d.cnt  = q.cnt - CNT_W'(1);
                    end else if (hold_full) begin
                        pop_o  = 1'b1;
                        d.line = frame_i[0];
                        d.sh   = {1'b1, frame_i[FRAME_W-1:1]};
                        d.cnt  = len_i - CNT_W'(1);
                    end else begin
                        d.line  = 1'b1;
                        d.state = SH_IDLE;
                    end
                end
            end
            default: begin
                d.state = SH_IDLE;
                d.line  = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state <= SH_IDLE;
            q.sh    <= '1;
            q.cnt   <= '0;
            q.line  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign line_o  = q.line;
    assign empty_o = (q.state == SH_IDLE);

    // R2: the line moves only on a tick edge
    a_r2_line_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.line) |-> $past(tick));

    // R8: going idle leaves the line high
    a_r8_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(empty_o) |-> q.line);

    // R5: remaining-bit count never exceeds the longest frame
    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNT_W'(FRAME_W));

endmodule

// File: rtl/dbuf_uart_tx.sv
module dbuf_uart_tx #(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        cfg_width,
    input  logic              cfg_parity,
    input  logic              cfg_two_stop,
    output logic              tx_line,
    output logic              hold_empty,
    output logic              shift_empty
);
    localparam int FRAME_W = DATA_W + 4;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    logic               hold_full;
    logic [DATA_W-1:0]  hold_data;
    logic               pop;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   frame_len;

    utx_hold_reg #(.DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .pop     (pop),
        .full_o  (hold_full),
        .data_o  (hold_data)
    );

    utx_framer #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_framer (
        .data_i      (hold_data),
        .width_i     (cfg_width),
        .parity_en_i (cfg_parity),
        .two_stop_i  (cfg_two_stop),
        .frame_o     (frame),
        .len_o       (frame_len)
    );

    utx_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (baud_tick),
        .hold_full (hold_full),
        .frame_i   (frame),
        .len_i     (frame_len),
        .pop_o     (pop),
        .line_o    (tx_line),
        .empty_o   (shift_empty)
    );

    assign hold_empty = !hold_full;

    // R1: an idle shifter keeps the line high
    a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        shift_empty |-> tx_line);

    // R6: the shifter only leaves idle when a word was staged
    a_r6_load_from_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shift_empty) |-> $past(!hold_empty));

endmodule

// File: tb/dbuf_uart_tx_test.sv
module dbuf_uart_tx_test;
    localparam int DATA_W  = 9;
    localparam int FRAME_W = DATA_W + 4;
    localparam int DIV     = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              baud_tick = 1'b0;
    logic              wr_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [1:0]        cfg_width = 2'd1;
    logic              cfg_parity = 1'b0;
    logic              cfg_two_stop = 1'b0;
    logic              tx_line, hold_empty, shift_empty;

    int  checks = 0;
    int  fails = 0;
    bit  tick_on = 1'b0;
    int  div_cnt = 0;
    bit  done = 1'b0;

    dbuf_uart_tx #(.DATA_W(DATA_W)) uut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
        .wr_data(wr_data), .cfg_width(cfg_width), .cfg_parity(cfg_parity),
        .cfg_two_stop(cfg_two_stop), .tx_line(tx_line),
        .hold_empty(hold_empty), .shift_empty(shift_empty)
    );

    always @(negedge clk) begin
        if (!tick_on) begin
            div_cnt   <= 0;
            baud_tick <= 1'b0;
        end else begin
            baud_tick <= (div_cnt == DIV - 1);
            div_cnt   <= (div_cnt == DIV - 1) ? 0 : div_cnt + 1;
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: run hung actual=running expected=finished");
        finish_run();
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic void build(input logic [DATA_W-1:0] dat, input logic [1:0] wc,
                                  input bit par, input bit two,
                                  output logic [FRAME_W-1:0] bits, output int n);
        int nb;
        bit p;
        nb = (wc == 2'd0) ? 7 : ((wc == 2'd2) ? 9 : 8);
        bits = '1;
        bits[0] = 1'b0;
        p = 1'b0;
        for (int i = 0; i < nb; i++) begin
            bits[1 + i] = dat[i];
            p ^= dat[i];
        end
        n = 1 + nb;
        if (par) begin
            bits[n] = p;
            n++;
        end
        n += two ? 2 : 1;
    endfunction

    task automatic wait_tick();
        do @(posedge clk); while (!baud_tick);
        @(negedge clk);
    endtask

    task automatic write_word(input logic [DATA_W-1:0] dat);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = dat;
        @(posedge clk);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic recv(input logic [DATA_W-1:0] dat, input logic [1:0] wc, input bit par,
                        input bit two, input bit started, input bit b2b, input string req);
        logic [FRAME_W-1:0] exp_bits, got;
        int n;
        build(dat, wc, par, two, exp_bits, n);
        got = '1;
        if (!started) begin
            int k = 0;
            do begin
                wait_tick();
                k++;
            end while (tx_line && k < 40);
        end
        got[0] = tx_line;
        for (int i = 1; i < n; i++) begin
            wait_tick();
            got[i] = tx_line;
            if (i == n - 1)
                chk(shift_empty == 1'b0, "R8", "busy during last stop", int'(shift_empty), 0);
        end
        chk(got == exp_bits, req, "frame bits", int'(got), int'(exp_bits));
        wait_tick();
        if (b2b) begin
            chk(tx_line == 1'b0, "R10", "next start directly after stop", int'(tx_line), 0);
        end else begin
            chk(tx_line == 1'b1, "R8", "line high after frame", int'(tx_line), 1);
            chk(shift_empty == 1'b1, "R8", "shift_empty after frame", int'(shift_empty), 1);
        end
    endtask

    task automatic t_reset();
        chk(tx_line == 1'b1, "R1", "reset line", int'(tx_line), 1);
        chk(hold_empty == 1'b1, "R1", "reset hold_empty", int'(hold_empty), 1);
        chk(shift_empty == 1'b1, "R1", "reset shift_empty", int'(shift_empty), 1);
    endtask

    task automatic t_basic();
        tick_on = 1'b0;
        cfg_width = 2'd1; cfg_parity = 1'b0; cfg_two_stop = 1'b0;
        write_word(9'h0A5);
        chk(hold_empty == 1'b0, "R7", "hold_empty after write", int'(hold_empty), 0);
        @(negedge clk);
        chk(hold_empty == 1'b1, "R6", "hold drained", int'(hold_empty), 1);
        chk(shift_empty == 1'b0, "R6", "shifter loaded", int'(shift_empty), 0);
        repeat (3) @(negedge clk);
        chk(tx_line == 1'b1, "R6", "line waits for tick", int'(tx_line), 1);
        tick_on = 1'b1;
        recv(9'h0A5, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
    endtask

    task automatic t_seven_parity();
        tick_on = 1'b0;
        cfg_width = 2'd0; cfg_parity = 1'b1; cfg_two_stop = 1'b0;
        write_word(9'h1D7);
        tick_on = 1'b1;
        recv(9'h1D7, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, "R3");
        tick_on = 1'b0;
        cfg_width = 2'd3;
        write_word(9'h03C);
        tick_on = 1'b1;
        recv(9'h03C, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, "R4");
    endtask

    task automatic t_nine_two_stop();
        tick_on = 1'b0;
        cfg_width = 2'd2; cfg_parity = 1'b1; cfg_two_stop = 1'b1;
        write_word(9'h13C);
        tick_on = 1'b1;
        recv(9'h13C, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, "R5");
        tick_on = 1'b0;
        cfg_parity = 1'b0;
        write_word(9'h1F1);
        tick_on = 1'b1;
        recv(9'h1F1, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, "R3");
    endtask

    task automatic t_back_to_back();
        bit quiet;
        tick_on = 1'b0;
        cfg_width = 2'd1; cfg_parity = 1'b0; cfg_two_stop = 1'b1;
        write_word(9'h05A);
        @(negedge clk);
        write_word(9'h0C3);
        chk(hold_empty == 1'b0, "R7", "hold full while shifting", int'(hold_empty), 0);
        write_word(9'h011);
        chk(hold_empty == 1'b0, "R9", "still full after ignored write", int'(hold_empty), 0);
        tick_on = 1'b1;
        recv(9'h05A, 2'd1, 1'b0, 1'b1, 1'b0, 1'b1, "R10");
        chk(hold_empty == 1'b1, "R7", "hold drained at back-to-back start", int'(hold_empty), 1);
        recv(9'h0C3, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, "R9");
        quiet = 1'b1;
        for (int i = 0; i < 20; i++) begin
            wait_tick();
            quiet &= tx_line;
        end
        chk(quiet, "R9", "no frame for ignored write", int'(quiet), 1);
    endtask

    task automatic t_cfg_latch();
        tick_on = 1'b0;
        cfg_width = 2'd1; cfg_parity = 1'b0; cfg_two_stop = 1'b0;
        write_word(9'h096);
        @(negedge clk);
        cfg_width = 2'd0; cfg_parity = 1'b1; cfg_two_stop = 1'b1;
        tick_on = 1'b1;
        recv(9'h096, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, "R11");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_seven_parity();
        t_nine_two_stop();
        t_back_to_back();
        t_cfg_latch();
        finish_run();
    end

endmodule